// File: doc/BRIEF.md
# Free-Running Timer with Compare and Capture Channels

A 16-bit up-counter runs continuously from zero to its all-ones value, wraps back to zero and keeps going; every wrap sets a sticky overflow flag. Next to the counter sit two channel registers. Channel A is always a compare register. Channel B works either as a second compare register or as a capture register that stores the count when a selected edge arrives on an external input. A compare match on either channel pulses that channel's interrupt line and inverts one shared timer output. No match ever clears the counter.

Software reaches the block through a small write/read port with four word addresses. A run bit in the control word starts the counter. Clearing the run bit stops it, forces the count to zero and drives the timer output to a programmable initial level. A separate count-enable input qualifies each increment, so the counter can be frozen without being cleared.

Top module: `frt_capcmp`

## Requirements
- R1: While the run bit (control bit 0) is 1, the count rises by one on each clock where cnt_en_i is 1 and holds on each clock where cnt_en_i is 0. Writes to address 3 (count) have no effect.
- R2: When an increment wraps the count from 16'hFFFF to 16'h0000, ovf_o becomes 1 and stays 1. A control write with bit 5 equal to 0 clears it, and a control write with bit 5 equal to 1 leaves it unchanged. When a wrap and a clearing write fall on the same clock, the flag is set.
- R3: After reset every output and register reads 0. While the run bit is 0, the count is held at 0 and tout_o follows the initial-level bit (control bit 4) one clock later.
- R4: When an increment makes the count equal to the channel A register (address 1), irq_a_o is 1 for exactly the clock in which that count is visible. A write to the register is used for compares from the following clock onward.
- R5: When channel B is in compare mode (control bit 1 is 0) and an increment makes the count equal to the channel B register (address 2), irq_b_o pulses in the same way.
- R6: Every compare match inverts tout_o in the clock where the matching count appears. When A and B match on the same clock, tout_o inverts only once and both interrupts pulse.
- R7: In capture mode (control bit 1 is 1), cap_i passes through two synchronizer flops and is then compared with its previous sampled value. Control bits [3:2] select the edges: 01 rising, 10 falling, 11 both, 00 none. A selected edge copies the current count into the channel B register and pulses irq_b_o three clocks after the input changes. Channel B then makes no compare matches, and a capture overrides a software write to address 2 on the same clock.
- R8: rdata_o reads combinationally from addr_i. Address 0 gives {ovf, init, edge[1:0], mode, run} in bits 5:0 with the upper bits zero. Address 1 gives channel A, address 2 gives channel B, and address 3 gives the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cnt_en_i | input | 1 | Count enable qualifier |
| cap_i | input | 1 | External capture input, asynchronous |
| irq_a_o | output | 1 | Channel A compare interrupt pulse |
| irq_b_o | output | 1 | Channel B compare or capture interrupt pulse |
| tout_o | output | 1 | Shared toggle output |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The two compare channels can match on the same clock. This tests whether the shared output inverts once or twice. The bench forces the case by loading both registers with the same value ahead of the count, and it also lets the random phase place both registers a few counts ahead so that they collide. A cycle-level reference model computed from the requirements judges every clock on the interrupts, the output level and the read data. A second collision is a counter wrap on the same clock as a software write that clears the flag. The bench provokes it during the long run to full scale and expects the set to win.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_CHA  = 2'd1,
    ADR_CHB  = 2'd2,
    ADR_CNT  = 2'd3
  } frt_addr_e;

  localparam int unsigned EDGE_RISE = 0;
  localparam int unsigned EDGE_FALL = 1;
  localparam int unsigned CTRL_W    = 5;
  localparam int unsigned OVF_BIT   = 5;

  typedef struct packed {
    logic       init;
    logic [1:0] edg;
    logic       capm;
    logic       run;
  } frt_ctrl_t;
endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         en_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         inc_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  assign inc_o = run_i & en_i;
  assign nxt_o = cnt_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (!run_i) cnt_o <= '0;
    else if (inc_o)  cnt_o <= nxt_o;
  end

  // set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ovf_o <= 1'b0;
    else if (inc_o && cnt_o == CNT_MAX)  ovf_o <= 1'b1;
    else if (ovf_clr_i)                  ovf_o <= 1'b0;
  end

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i && en_i) |-> cnt_o == $past(cnt_o) + 1'b1);
  assert_count_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i && !en_i) |-> $stable(cnt_o));
  assert_stop_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!run_i) |-> cnt_o == '0);
  assert_wrap_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inc_o && cnt_o == CNT_MAX) |-> ovf_o && cnt_o == '0);
  assert_ovf_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_o) |-> $past(ovf_clr_i));
endmodule

// File: rtl/frt_edge_det.sv
module frt_edge_det
  import frt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_i,
  input  logic [1:0] sel_i,
  output logic       evt_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], in_i};
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign evt_o = (sel_i[EDGE_RISE] &  sh_q[1] & ~sh_q[2])
               | (sel_i[EDGE_FALL] & ~sh_q[1] &  sh_q[2]);

  assert_no_edge_unselected_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b00) |-> !evt_o);
endmodule

// File: rtl/frt_channel.sv
module frt_channel #(
  parameter int unsigned W      = 16,
  parameter bit          CAP_EN = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  input  logic [W-1:0] nxt_i,
  input  logic [W-1:0] cnt_i,
  input  logic         capm_i,
  input  logic         cap_evt_i,
  output logic [W-1:0] val_o,
  output logic         hit_o,
  output logic         irq_o
);
  logic cap, cmp_on;

  generate
    if (CAP_EN) begin : g_cap
      assign cap    = capm_i & cap_evt_i;
      assign cmp_on = ~capm_i;
    end else begin : g_cmp
      logic unused_cap;
      assign unused_cap = capm_i ^ cap_evt_i;
      assign cap    = 1'b0;
      assign cmp_on = 1'b1;
    end
  endgenerate

  assign hit_o = inc_i & cmp_on & (nxt_i == val_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_o <= '0;
    else if (cap)  val_o <= cnt_i;
    else if (wr_i) val_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= hit_o | cap;
  end

  assert_match_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(cap)) |-> cnt_i == $past(val_o));
  assert_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cap) |-> (irq_o && val_o == $past(cnt_i)));
  assert_no_cmp_in_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CAP_EN && capm_i) |-> !hit_o);
endmodule

// File: rtl/frt_capcmp.sv
module frt_capcmp
  import frt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         cnt_en_i,
  input  logic         cap_i,
  output logic         irq_a_o,
  output logic         irq_b_o,
  output logic         tout_o,
  output logic         ovf_o
);
  frt_ctrl_t    ctrl_q;
  logic [W-1:0] cnt, nxt, val_a, val_b;
  logic         inc, hit_a, hit_b, cap_evt;
  logic         wr_ctrl, wr_a, wr_b;

  assign wr_ctrl = wr_i && addr_i == ADR_CTRL;
  assign wr_a    = wr_i && addr_i == ADR_CHA;
  assign wr_b    = wr_i && addr_i == ADR_CHB;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= frt_ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  frt_counter #(.W(W)) i_cnt (
    .clk_i, .rst_ni,
    .run_i     (ctrl_q.run),
    .en_i      (cnt_en_i),
    .ovf_clr_i (wr_ctrl && !wdata_i[OVF_BIT]),
    .cnt_o     (cnt),
    .nxt_o     (nxt),
    .inc_o     (inc),
    .ovf_o     (ovf_o)
  );

  frt_edge_det i_edge (
    .clk_i, .rst_ni,
    .in_i  (cap_i),
    .sel_i (ctrl_q.edg),
    .evt_o (cap_evt)
  );

  frt_channel #(.W(W), .CAP_EN(1'b0)) i_cha (
    .clk_i, .rst_ni,
    .wr_i (wr_a), .wdata_i,
    .inc_i (inc), .nxt_i (nxt), .cnt_i (cnt),
    .capm_i (1'b0), .cap_evt_i (1'b0),
    .val_o (val_a), .hit_o (hit_a), .irq_o (irq_a_o)
  );

  frt_channel #(.W(W), .CAP_EN(1'b1)) i_chb (
    .clk_i, .rst_ni,
    .wr_i (wr_b), .wdata_i,
    .inc_i (inc), .nxt_i (nxt), .cnt_i (cnt),
    .capm_i (ctrl_q.capm), .cap_evt_i (cap_evt),
    .val_o (val_b), .hit_o (hit_b), .irq_o (irq_b_o)
  );

  // one inversion per clock even when both channels match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             tout_o <= 1'b0;
    else if (!ctrl_q.run)    tout_o <= ctrl_q.init;
    else if (hit_a || hit_b) tout_o <= ~tout_o;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTRL: rdata_o[OVF_BIT:0] = {ovf_o, ctrl_q};
      ADR_CHA:  rdata_o = val_a;
      ADR_CHB:  rdata_o = val_b;
      default:  rdata_o = cnt;
    endcase
  end

  assert_toggle_on_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_q.run && (hit_a || hit_b)) |-> tout_o != $past(tout_o));
  assert_toggle_only_on_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_q.run && !hit_a && !hit_b) |-> $stable(tout_o));
  assert_idle_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctrl_q.run) |-> tout_o == $past(ctrl_q.init));
  assert_irq_a_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_a_o |-> $past(ctrl_q.run && cnt_en_i));
endmodule

// File: tb/test_frt_capcmp.sv
module test_frt_capcmp;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, cnt_en = 1'b0, cap = 1'b0;
  logic [1:0] addr = 2'd3;
  logic [W-1:0] wdata = '0, rdata;
  logic irq_a, irq_b, tout, ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic m_run, m_capm, m_init, m_ovf, m_tout, m_irqa, m_irqb;
  logic [1:0] m_edg;
  logic [2:0] m_sh;
  logic [W-1:0] m_cnt, m_cha, m_chb;

  always #(CLK_PERIOD/2) clk = ~clk;

  frt_capcmp #(.W(W)) i_frt_capcmp (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cnt_en_i(cnt_en), .cap_i(cap),
    .irq_a_o(irq_a), .irq_b_o(irq_b), .tout_o(tout), .ovf_o(ovf)
  );

  function automatic logic [W-1:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return W'({m_ovf, m_init, m_edg, m_capm, m_run});
      2'd1:    return m_cha;
      2'd2:    return m_chb;
      default: return m_cnt;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(irq_a == m_irqa, "R4 irq_a", W'(irq_a), W'(m_irqa));
    chk(irq_b == m_irqb, m_capm ? "R7 irq_b" : "R5 irq_b", W'(irq_b), W'(m_irqb));
    chk(tout == m_tout, m_run ? "R6 tout" : "R3 tout", W'(tout), W'(m_tout));
    chk(ovf == m_ovf, "R2 ovf", W'(ovf), W'(m_ovf));
    chk(rdata == exp_rd(addr), addr == 2'd3 ? "R1 count" : "R8 read", rdata, exp_rd(addr));
  endtask

  // one clock: model steps on pre-edge values, outputs checked at the next negedge
  task automatic tick(input logic w, input logic [1:0] a, input logic [W-1:0] d);
    logic inc, ev, ma, mb;
    logic [W-1:0] nx;
    wr = w; addr = a; wdata = d;
    inc = m_run & cnt_en;
    nx  = m_cnt + 1'b1;
    ev  = m_capm & ((m_edg[0] & m_sh[1] & ~m_sh[2]) | (m_edg[1] & ~m_sh[1] & m_sh[2]));
    ma  = inc && nx == m_cha;
    mb  = inc && !m_capm && nx == m_chb;
    @(posedge clk);
    if (inc && m_cnt == '1) m_ovf = 1'b1;
    else if (w && a == 2'd0 && !d[5]) m_ovf = 1'b0;
    m_irqa = ma;
    m_irqb = mb | ev;
    if (!m_run) m_tout = m_init;
    else if (ma | mb) m_tout = ~m_tout;
    if (ev) m_chb = m_cnt;
    else if (w && a == 2'd2) m_chb = d;
    if (w && a == 2'd1) m_cha = d;
    m_sh  = {m_sh[1:0], cap};
    m_cnt = !m_run ? '0 : (inc ? nx : m_cnt);
    if (w && a == 2'd0) {m_init, m_edg, m_capm, m_run} = d[4:0];
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 2'd3, '0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    {m_run, m_capm, m_init, m_ovf, m_tout, m_irqa, m_irqb} = '0;
    m_edg = '0; m_sh = '0; m_cnt = '0; m_cha = '0; m_chb = '0;
    repeat (3) @(negedge clk);
    // R3 reset state
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      chk(rdata == '0, "R3 reset read", rdata, '0);
    end
    chk({irq_a, irq_b, tout, ovf} == 4'b0, "R3 reset outs", W'({irq_a, irq_b, tout, ovf}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: equal compare values, single toggle; init level 1 while stopped (R3)
    tick(1'b1, 2'd1, 16'd5);
    tick(1'b1, 2'd2, 16'd5);
    tick(1'b1, 2'd0, 16'h0010);
    idle(2);
    chk(tout == 1'b1, "R3 init level", W'(tout), 16'd1);
    tick(1'b1, 2'd0, 16'h0011);
    cnt_en = 1'b1;
    idle(8);
    // R4/R5: separate values; R8: count write ignored
    tick(1'b1, 2'd2, 16'd12);
    tick(1'b1, 2'd3, 16'hAAAA);
    idle(6);
    cnt_en = 1'b0;
    idle(3);

    // R7: capture, each edge selection, with the count frozen
    tick(1'b1, 2'd0, 16'h0007);
    for (int s = 0; s < 4; s++) begin
      tick(1'b1, 2'd0, W'({s[1:0], 2'b11}));
      cap = 1'b1; idle(5);
      cnt_en = 1'b1; idle(3); cnt_en = 1'b0;
      cap = 1'b0; idle(5);
      addr = 2'd2; #1;
      chk(rdata == m_chb, "R7 captured value", rdata, m_chb);
    end
    // capture vs software write on the same clock
    tick(1'b1, 2'd0, 16'h000F);
    cap = 1'b1; idle(2);
    tick(1'b1, 2'd2, 16'h1234);
    cap = 1'b0; idle(4);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      cnt_en = ($urandom % 4) != 0;
      if (($urandom % 3) == 0) cap = ~cap;
      r = $urandom % 16;
      if (r == 0)      tick(1'b1, 2'd0, W'({$urandom % 2'd2, ($urandom % 64 != 0) ? 1'b1 : 1'b0} | ($urandom & 16'h003E)));
      else if (r < 3)  tick(1'b1, 2'd1, m_cnt + W'($urandom % 6));
      else if (r < 5)  tick(1'b1, 2'd2, m_cnt + W'($urandom % 6));
      else if (r == 5) tick(1'b1, 2'd3, W'($urandom));
      else             tick(1'b0, 2'($urandom), '0);
    end

    // R2: long run through the wrap, set beats a clearing write
    cnt_en = 1'b0; cap = 1'b0;
    tick(1'b1, 2'd0, 16'h0000);
    tick(1'b1, 2'd0, 16'h0001);
    tick(1'b1, 2'd1, 16'h0000);
    tick(1'b1, 2'd2, 16'hFFFF);
    cnt_en = 1'b1;
    while (m_cnt != 16'hFFFF) tick(1'b0, 2'd3, '0);
    tick(1'b1, 2'd0, 16'h0001);
    chk(ovf == 1'b1, "R2 wrap set", W'(ovf), 16'd1);
    idle(3);
    tick(1'b1, 2'd0, 16'h0021);
    chk(ovf == 1'b1, "R2 write one keeps", W'(ovf), 16'd1);
    tick(1'b1, 2'd0, 16'h0001);
    chk(ovf == 1'b0, "R2 write zero clears", W'(ovf), 16'd0);
    idle(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule